// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Group

This block holds four down-counting timers that share one prescaled tick and one group control word. Each timer has a reload value with a halt flag, a readable running count with a flip-on-expiry flag, and two plain 32-bit storage words for the interrupt controller's use. Each timer drives a level interrupt when its count runs out. The interrupt stays high until software clears it.

Any neighbouring pair of timers can be joined into one wide counter. The lower timer then runs on the prescaled tick, and the upper timer counts how many times the lower one has wrapped. Software programs the block through a small synchronous register port. Writes take effect at the next clock edge, and read data follows one cycle after the address.

Top module: `tmr_quad_grp`

## Requirements
- R1: After reset every reload word reads 0x8000_0000 (halted, value 0), every running count, vector word, destination word and the group control word read 0, and all four interrupts are low.
- R2: Register index `bus_addr` = {0, timer[1:0], reg[1:0]} selects, by reg, the running count (0), reload (1), vector (2) or destination (3) of a timer. 5'h10 is group control and 5'h11 is the interrupt clear/status word. Read data appears on `bus_rdata` one cycle after the address. Vector and destination words store and return all 32 bits.
- R3: Bits 9:8 of group control set the clocks per tick: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R4: A running unpaired timer decrements once per tick. The tick that takes it to zero raises its interrupt and reloads bits 30:0 of its reload word, so it expires every reload × tick-period clocks, and only on a tick.
- R5: While bit 31 of a timer's reload word is 1 its count is frozen. Writing the reload word with bit 31 cleared resumes from the held count, or loads the reload value when the held count is zero.
- R6: Bit 31 of a running-count read is a flag that inverts on every expiry, and bits 30:0 are the count. Writing the running count loads bits 30:0 (all 32 bits for the lower timer of a pair) and clears the flag.
- R7: An interrupt stays high until a write to 5'h11 has a 1 in that timer's bit (bits 3:0). A 0 bit leaves that interrupt unchanged, and a read of 5'h11 returns the four interrupt levels in bits 3:0.
- R8: Group control bits 0, 1 and 2 pair timers 0+1, 1+2 and 2+3. When requested pairs overlap, the lower-numbered pair wins and the other request is ignored. The upper timer's halt flag runs the whole pair, the lower timer never interrupts, and its count reads as a full 32-bit value.
- R9: In a pair, a tick that finds the lower count at zero while the upper count is non-zero decrements the upper count and sets the lower count to 0xFFFF_FFFE, so the ticks left are upper × 0xFFFF_FFFF + lower.
- R10: When both halves of a pair run out, the upper timer's interrupt and flag fire. If the pair's rollover bit (group control bit 24 + pair number) is set, both halves reload and the pair repeats. If it is clear, the pair fires once and then holds at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| irq | output | 4 | Per-timer level interrupts |

## Verification
A register write lands at the clock edge that samples it, and its read-back is due one cycle after the address is presented. The bench drives on falling edges and samples `bus_rdata` at the next falling edge. It also confirms that the old data is still present just after the address changes. The tick phase relative to a start write is not fixed, so the bench times expiry from one interrupt rise to the next, which must be exactly reload × clocks-per-tick. Start-to-expiry and borrow results are checked against the one-tick window the phase allows. A frozen count, a held interrupt and a pair left at zero are each read back after a wait long enough for several ticks.

// File: rtl/tmr_quad_grp.sv
module tmr_quad_grp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [3:0]  irq
);
  localparam int NT = 4;
  localparam int NP = NT - 1;
  localparam logic [31:0] HALT = 32'h8000_0000;

  logic [NT-1:0][31:0] cnt, base, vec, dst;
  logic [NT-1:0] tog, irq_q, stp, lo_role, hi_role;
  logic [NP-1:0] casc, rovr, pair;
  logic [1:0] ratio, aidx;
  logic [5:0] pre, pre_lim;
  logic tick, tmr_wr, gc_wr, clr_wr;

  assign pre_lim = 6'((7'd8 << ratio) - 7'd1);
  assign tick    = pre >= pre_lim;
  assign pair    = {casc[2] & ~(casc[1] & ~casc[0]), casc[1] & ~casc[0], casc[0]};
  assign lo_role = {1'b0, pair};
  assign hi_role = {pair, 1'b0};
  assign aidx    = bus_addr[3:2];
  assign tmr_wr  = bus_we & ~bus_addr[4];
  assign gc_wr   = bus_we & (bus_addr == 5'h10);
  assign clr_wr  = bus_we & (bus_addr == 5'h11);
  assign irq     = irq_q;

  for (genvar g = 0; g < NT; g++) begin : g_stp
    assign stp[g] = base[g][31];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      casc  <= '0;
      rovr  <= '0;
      ratio <= '0;
      tog   <= '0;
      irq_q <= '0;
      for (int i = 0; i < NT; i++) begin
        cnt[i]  <= '0;
        base[i] <= HALT;
        vec[i]  <= '0;
        dst[i]  <= '0;
      end
    end else begin
      pre <= tick ? '0 : pre + 6'd1;
      if (clr_wr) irq_q <= irq_q & ~bus_wdata[NT-1:0];

      for (int i = 0; i < NT; i++) begin
        if (tick && !stp[i] && !lo_role[i] && !hi_role[i]) begin
          if (cnt[i][30:0] <= 31'd1) begin
            cnt[i]   <= {1'b0, base[i][30:0]};
            tog[i]   <= ~tog[i];
            irq_q[i] <= 1'b1;
          end else begin
            cnt[i] <= cnt[i] - 32'd1;
          end
        end
      end

      for (int p = 0; p < NP; p++) begin
        if (tick && pair[p] && !stp[p+1]) begin
          if (cnt[p+1][30:0] == '0 && cnt[p] <= 32'd1) begin
            if (rovr[p]) begin
              cnt[p]     <= base[p];
              cnt[p+1]   <= {1'b0, base[p+1][30:0]};
              tog[p+1]   <= ~tog[p+1];
              irq_q[p+1] <= 1'b1;
            end else if (cnt[p][0]) begin
              cnt[p]     <= '0;
              tog[p+1]   <= ~tog[p+1];
              irq_q[p+1] <= 1'b1;
            end
          end else if (cnt[p] == '0) begin
            cnt[p+1] <= cnt[p+1] - 32'd1;
            cnt[p]   <= 32'hFFFF_FFFE;
          end else begin
            cnt[p] <= cnt[p] - 32'd1;
          end
        end
      end

      if (gc_wr) begin
        casc  <= bus_wdata[2:0];
        ratio <= bus_wdata[9:8];
        rovr  <= bus_wdata[26:24];
      end

      if (tmr_wr) begin
        case (bus_addr[1:0])
          2'd0: begin
            cnt[aidx] <= lo_role[aidx] ? bus_wdata : {1'b0, bus_wdata[30:0]};
            tog[aidx] <= 1'b0;
          end
          2'd1: begin
            base[aidx] <= bus_wdata;
            if (stp[aidx] && !bus_wdata[31] && !lo_role[aidx]) begin
              if (hi_role[aidx]) begin
                if (cnt[aidx][30:0] == '0 && cnt[aidx-2'd1] == '0) begin
                  cnt[aidx]       <= {1'b0, bus_wdata[30:0]};
                  cnt[aidx-2'd1]  <= base[aidx-2'd1];
                end
              end else if (cnt[aidx][30:0] == '0) begin
                cnt[aidx] <= {1'b0, bus_wdata[30:0]};
              end
            end
          end
          2'd2:    vec[aidx] <= bus_wdata;
          default: dst[aidx] <= bus_wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_addr[4]) begin
      if (bus_addr == 5'h10)
        bus_rdata <= {5'd0, rovr, 14'd0, ratio, 5'd0, casc};
      else if (bus_addr == 5'h11)
        bus_rdata <= {28'd0, irq_q};
      else
        bus_rdata <= '0;
    end else begin
      case (bus_addr[1:0])
        2'd0:    bus_rdata <= lo_role[aidx] ? cnt[aidx] : {tog[aidx], cnt[aidx][30:0]};
        2'd1:    bus_rdata <= base[aidx];
        2'd2:    bus_rdata <= vec[aidx];
        default: bus_rdata <= dst[aidx];
      endcase
    end
  end
endmodule

// File: rtl/tmr_quad_grp_chk.sv
module tmr_quad_grp_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [3:0]       irq,
  input logic             tick,
  input logic [3:0]       lo_role,
  input logic [3:0]       hi_role,
  input logic [3:0]       stp,
  input logic [3:0][31:0] cnt
);
  logic clr_wr, gc_wr, gc_rd;
  assign clr_wr = bus_we && bus_addr == 5'h11;
  assign gc_wr  = bus_we && bus_addr == 5'h10;
  assign gc_rd  = !bus_we && bus_addr == 5'h10;

  // R2
  gc_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_rd && $past(gc_wr)) |=>
      (bus_rdata[9:8] == $past(bus_wdata[9:8], 2) && bus_rdata[2:0] == $past(bus_wdata[2:0], 2)));

  for (genvar k = 0; k < 4; k++) begin : g_k
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[k] && !(clr_wr && bus_wdata[k])) |=> irq[k]);

    // R4
    irq_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[k]) |-> $past(tick));

    // R8
    lower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_role[k] && !irq[k]) |=> !irq[k]);

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stp[k] && !lo_role[k] && !hi_role[k] && !bus_we) |=> $stable(cnt[k]));
  end
endmodule

bind tmr_quad_grp tmr_quad_grp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tick(tick),
  .lo_role(lo_role), .hi_role(hi_role), .stp(stp), .cnt(cnt)
);

// File: tb/tmr_quad_grp_tb_top.sv
module tmr_quad_grp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 100000;
  localparam int NROW = 5;
  // {ratio[39:32], reload[31:16], expected clocks between expiries[15:0]}
  localparam logic [39:0] TBL [NROW] = '{
    {8'd0, 16'd4, 16'd32},
    {8'd1, 16'd3, 16'd48},
    {8'd2, 16'd2, 16'd64},
    {8'd3, 16'd1, 16'd64},
    {8'd0, 16'd1, 16'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  int unsigned cyc = 0, n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  tmr_quad_grp dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [4:0] a_cur(int i);  return 5'(i*4);     endfunction
  function automatic logic [4:0] a_base(int i); return 5'(i*4 + 1); endfunction
  function automatic logic [4:0] a_vec(int i);  return 5'(i*4 + 2); endfunction
  function automatic logic [4:0] a_dst(int i);  return 5'(i*4 + 3); endfunction
  localparam logic [4:0] A_GC = 5'h10;
  localparam logic [4:0] A_IC = 5'h11;

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_irq(input int k, output int unsigned t);
    while (!irq[k]) @(negedge clk);
    t = cyc;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v1;
    int unsigned t1, t2, ts;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {28'd0, irq}, 32'd0);
    rd(a_base(2), v); chk("R1 reload", v, 32'h8000_0000);
    rd(A_GC, v);      chk("R1 group ctrl", v, 32'd0);
    rd(a_cur(1), v);  chk("R1 count", v, 32'd0);
    rd(a_vec(3), v);  chk("R1 vector", v, 32'd0);

    // R2 storage and one-cycle read latency
    wr(a_vec(3), 32'hA5A5_1234);
    wr(a_dst(0), 32'h0F0F_F0F0);
    rd(a_dst(0), v); chk("R2 destination", v, 32'h0F0F_F0F0);
    bus_addr = a_vec(3);
    #1 chk("R2 latency old data", bus_rdata, 32'h0F0F_F0F0);
    @(negedge clk);
    chk("R2 vector", bus_rdata, 32'hA5A5_1234);

    // R3 R4 prescaler ratios and reload period, timer 0
    for (int r = 0; r < NROW; r++) begin
      logic [31:0] b;
      b = {16'd0, TBL[r][31:16]};
      wr(A_GC, {22'd0, TBL[r][33:32], 8'd0});
      wr(a_base(0), 32'h8000_0000 | b);
      wr(a_cur(0), 32'd0);
      wr(A_IC, 32'h1);
      wr(a_base(0), b);
      wait_irq(0, t1);
      wr(A_IC, 32'h1);
      wait_irq(0, t2);
      chk("R3 R4 expiry interval", t2 - t1, {16'd0, TBL[r][15:0]});
      wr(a_base(0), 32'h8000_0000 | b);
      wr(A_IC, 32'h1);
    end

    // R6 flag flips on expiry; count write clears it
    wr(A_GC, 32'd0);
    wr(a_base(1), 32'h8000_0005);
    wr(a_cur(1), 32'd0);
    wr(A_IC, 32'hF);
    wr(a_base(1), 32'd5);
    wait_irq(1, t1);
    wr(a_base(1), 32'h8000_0005);
    wr(A_IC, 32'h2);
    rd(a_cur(1), v);
    chk("R6 flag set", {31'd0, v[31]}, 32'd1);
    chk("R6 count after reload", {31'd0, (v[30:0] >= 31'd4 && v[30:0] <= 31'd5)}, 32'd1);
    wr(a_cur(1), 32'd0);
    rd(a_cur(1), v); chk("R6 count write", v, 32'd0);

    // R5 halt freezes, resume continues from held count
    wr(a_cur(2), 32'd0);
    wr(a_base(2), 32'd100);
    repeat (200) @(negedge clk);
    wr(a_base(2), 32'h8000_0064);
    rd(a_cur(2), v1);
    repeat (300) @(negedge clk);
    rd(a_cur(2), v);
    chk("R5 frozen count", v, v1);
    chk("R5 no expiry while halted", {31'd0, irq[2]}, 32'd0);
    chk("R5 held count in range", {31'd0, (v1[30:0] >= 31'd2 && v1[30:0] < 31'd100)}, 32'd1);
    wr(a_base(2), 32'd100);
    ts = cyc;
    wait_irq(2, t1);
    chk("R5 resume from held count",
        {31'd0, ((t1 - ts) >= (v1 - 1) * 8 + 1 && (t1 - ts) <= v1 * 8)}, 32'd1);

    // R7 level hold and selective clear
    wr(a_base(2), 32'h8000_0064);
    wr(A_IC, 32'h1);
    chk("R7 other bit leaves irq", {31'd0, irq[2]}, 32'd1);
    rd(A_IC, v); chk("R7 status", v, 32'h4);
    repeat (50) @(negedge clk);
    chk("R7 held", {31'd0, irq[2]}, 32'd1);
    wr(A_IC, 32'h4);
    chk("R7 cleared", {28'd0, irq}, 32'd0);

    // R8 overlapping pair requests: pair 0 wins, timer 2 stays unpaired
    wr(A_GC, 32'h0100_0003);
    wr(a_cur(2), 32'd0);
    wr(a_base(2), 32'd3);
    wait_irq(2, t1);
    wr(A_IC, 32'h4);
    wait_irq(2, t2);
    chk("R8 overlap ignored", t2 - t1, 32'd24);
    chk("R8 halted pair quiet", {31'd0, irq[1]}, 32'd0);
    wr(a_base(2), 32'h8000_0003);
    wr(A_IC, 32'hF);

    // R10 rollover set: pair repeats; R8 lower never interrupts
    wr(A_GC, 32'h0100_0001);
    wr(a_base(1), 32'h8000_0000);
    wr(a_cur(1), 32'd0);
    wr(a_cur(0), 32'd0);
    wr(a_base(0), 32'd6);
    wr(A_IC, 32'hF);
    wr(a_base(1), 32'd0);
    wait_irq(1, t1);
    wr(A_IC, 32'h2);
    wait_irq(1, t2);
    chk("R10 rollover period", t2 - t1, 32'd48);
    chk("R8 lower timer silent", {31'd0, irq[0]}, 32'd0);
    wr(a_base(1), 32'h8000_0000);
    wr(A_IC, 32'hF);

    // R10 rollover clear: fires once then holds at zero
    wr(A_GC, 32'h0000_0001);
    wr(a_cur(1), 32'd0);
    wr(a_cur(0), 32'd0);
    wr(a_base(0), 32'd3);
    wr(a_base(1), 32'd0);
    wait_irq(1, t1);
    wr(A_IC, 32'h2);
    repeat (200) @(negedge clk);
    chk("R10 single expiry", {31'd0, irq[1]}, 32'd0);
    wr(a_base(1), 32'h8000_0000);
    rd(a_cur(0), v); chk("R10 lower at zero", v, 32'd0);
    rd(a_cur(1), v); chk("R10 upper at zero, flag set", v, 32'h8000_0000);

    // R9 borrow from upper half
    wr(A_GC, 32'h0100_0001);
    wr(a_cur(0), 32'd2);
    wr(a_cur(1), 32'd1);
    wr(a_base(1), 32'd0);
    repeat (60) @(negedge clk);
    wr(a_base(1), 32'h8000_0000);
    rd(a_cur(1), v); chk("R9 upper decremented", v, 32'd0);
    rd(a_cur(0), v); chk("R9 lower wrapped", {31'd0, v >= 32'hFFFF_FFF0}, 32'd1);
    chk("R9 no expiry", {31'd0, irq[1]}, 32'd0);

    summary();
    $finish;
  end
endmodule